// File: doc/BRIEF.md
# Digital Integer Frequency Multiplier Loop

This block produces a clock-enable stream whose rate is a fixed integer multiple of a slow reference pulse train. The whole loop is built from logic in the system clock domain. A phase-accumulator oscillator issues one-cycle enable pulses. Those pulses are divided by a selectable ratio of 3 or 6 and fed back. A comparator with separate advance and retard flags measures each divided pulse against the rising edge of the reference. The comparator then steers a saturating tuning register and adds a proportional kick to the oscillator increment. Once the loop settles, the enable rate equals the ratio times the reference rate.

The oscillator is meant to run at twice the rate that is finally wanted. A toggle stage halves it and gives a square output with an even duty cycle. A lock flag reports when the comparator has stayed close to idle for a run of reference periods. The reference input may be asynchronous to the system clock. Two loop gain inputs set the integral step size and the proportional kick size. Both are given as powers of two.

Top module: `fmul_loop`

## Requirements
- R1: While the synchronous reset is high, the outputs `mult_en`, `sq_out` and `locked` are 0, and the tuning word returns to its start value.
- R2: The reference passes through a chain of at least two synchronizing flops, and only its rising edges are used. A reference edge sets the advance flag and a feedback pulse sets the retard flag. When both flags would be set, both clear. When neither flag is set, the comparator is idle and the tuning word holds.
- R3: The tuning word has `TUNE_FRAC` fraction bits. While only the advance flag is set, it rises by 2^`i_gain` fraction units each cycle. While only the retard flag is set, it falls by the same step. It saturates at its minimum and maximum and never wraps.
- R4: The oscillator increment is the integer part of the tuning word. It is raised by 2^`p_gain` while only the advance flag is set, and lowered by the same amount while only the retard flag is set. It is clamped to the range 0 to 2^(`ACC_W`-1)-1. The accumulator carry is registered into `mult_en`, so `mult_en` is never high on two cycles in a row.
- R5: `sq_out` changes level in exactly those cycles in which `mult_en` is high.
- R6: `div_sel` = 0 selects feedback ratio 3 and `div_sel` = 1 selects ratio 6. In lock, the number of `mult_en` pulses over a window equals the ratio times the number of reference periods, within ±2.
- R7: A reference period is clean when no unbroken run of comparator activity in it lasts longer than 2 cycles. `locked` rises only on a reference edge, and only after 16 clean periods in a row. A period that is not clean clears `locked` at the next reference edge.
- R8: With the reference held low, no lock is ever claimed. The retard flag stays set, the tuning word settles at its minimum, and the pulse rate becomes that minimum less the kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference pulse input, may be asynchronous |
| div_sel | input | 1 | Feedback ratio select: 0 gives 3, 1 gives 6 |
| i_gain | input | $clog2(ACC_W+TUNE_FRAC) | Integral step exponent |
| p_gain | input | $clog2(ACC_W) | Proportional kick exponent |
| mult_en | output | 1 | One-cycle enable at the multiplied rate |
| sq_out | output | 1 | Square output at half the enable rate |
| locked | output | 1 | Loop lock indicator |

## Verification
The assertions check on every cycle the properties that need no knowledge of the reference. These are the tuning word bounds, the direction it moves under each comparator state, the hold while the comparator is idle, the spacing of enable pulses, the toggle relation between `sq_out` and `mult_en`, and that `locked` rises only right after a reference edge. Three things depend on the loop's dynamics, so only the bench scenarios can show them: the pulse count settling at the ratio times the reference count, lock being lost and regained after a ratio change, and the saturated pulse rates with the reference stuck or racing.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

   // Comparator steering state: advance (raise frequency) / retard (lower it)
   typedef struct packed {
      logic adv;
      logic ret;
   } steer_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fmul_pfd.sv
module fmul_pfd
   import fmul_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   ref_in,
   input  logic   fb_pulse,
   output logic   ref_edge,
   output steer_t steer
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   adv_q, ret_q;
   logic                   adv_n, ret_n;

   // synchronizer chain, one flop per stage
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) sync_q[0] <= 1'b0;
            else     sync_q[0] <= ref_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b0;
            else     sync_q[g] <= sync_q[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign ref_edge = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_comb begin
      adv_n = adv_q | ref_edge;
      ret_n = ret_q | fb_pulse;
      if (adv_n && ret_n) begin
         adv_n = 1'b0;
         ret_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         adv_q <= 1'b0;
         ret_q <= 1'b0;
      end else begin
         adv_q <= adv_n;
         ret_q <= ret_n;
      end
   end

   assign steer.adv = adv_q;
   assign steer.ret = ret_q;

endmodule

// File: rtl/fmul_tune.sv
module fmul_tune
   import fmul_pkg::*;
#(
   parameter int unsigned TUNE_W    = 20,
   parameter int unsigned IG_W      = 5,
   parameter int unsigned TUNE_MIN  = 16,
   parameter int unsigned TUNE_MAX  = 1024,
   parameter int unsigned TUNE_INIT = 256
) (
   input  logic              clk,
   input  logic              rst,
   input  steer_t            steer,
   input  logic [IG_W-1:0]   i_gain,
   output logic [TUNE_W-1:0] tune
);

   localparam logic [TUNE_W:0] LIM_LO = (TUNE_W+1)'(TUNE_MIN);
   localparam logic [TUNE_W:0] LIM_HI = (TUNE_W+1)'(TUNE_MAX);

   logic [TUNE_W-1:0] tune_q, tune_n;
   logic [TUNE_W:0]   step_w, cur_w, sum_w, floor_w;

   always_comb begin
      step_w  = (TUNE_W+1)'(1) << i_gain;
      cur_w   = {1'b0, tune_q};
      sum_w   = cur_w + step_w;
      floor_w = LIM_LO + step_w;
      tune_n  = tune_q;
      if (steer.adv && !steer.ret) begin
         tune_n = (sum_w > LIM_HI) ? LIM_HI[TUNE_W-1:0] : sum_w[TUNE_W-1:0];
      end else if (steer.ret && !steer.adv) begin
         tune_n = (cur_w < floor_w) ? LIM_LO[TUNE_W-1:0] : tune_q - step_w[TUNE_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) tune_q <= TUNE_W'(TUNE_INIT);
      else     tune_q <= tune_n;
   end

   assign tune = tune_q;

endmodule

// File: rtl/fmul_nco.sv
module fmul_nco
   import fmul_pkg::*;
#(
   parameter int unsigned ACC_W     = 16,
   parameter int unsigned TUNE_FRAC = 4,
   parameter int unsigned PG_W      = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [ACC_W+TUNE_FRAC-1:0]  tune,
   input  steer_t                      steer,
   input  logic [PG_W-1:0]             p_gain,
   output logic                        mult_en,
   output logic                        sq_out
);

   localparam int unsigned    WW       = ACC_W + 2;
   localparam logic [WW-1:0]  INC_CEIL = WW'((64'd1 << (ACC_W-1)) - 64'd1);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] inc;
   logic [ACC_W:0]   acc_sum;
   logic [WW-1:0]    base_w, kick_w, raw_w;
   logic             en_q, sq_q;

   always_comb begin
      base_w = {2'b00, tune[ACC_W+TUNE_FRAC-1:TUNE_FRAC]};
      kick_w = WW'(1) << p_gain;
      raw_w  = base_w;
      if (steer.adv && !steer.ret)      raw_w = base_w + kick_w;
      else if (steer.ret && !steer.adv) raw_w = (base_w < kick_w) ? '0 : base_w - kick_w;
      inc     = (raw_w > INC_CEIL) ? INC_CEIL[ACC_W-1:0] : raw_w[ACC_W-1:0];
      acc_sum = {1'b0, acc_q} + {1'b0, inc};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         en_q  <= 1'b0;
         sq_q  <= 1'b0;
      end else begin
         acc_q <= acc_sum[ACC_W-1:0];
         en_q  <= acc_sum[ACC_W];
         sq_q  <= sq_q ^ acc_sum[ACC_W];
      end
   end

   assign mult_en = en_q;
   assign sq_out  = sq_q;

endmodule

// File: rtl/fmul_fbdiv.sv
module fmul_fbdiv
   import fmul_pkg::*;
#(
   parameter int unsigned DIV_A = 3,
   parameter int unsigned DIV_B = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic sel,
   output logic fb_pulse
);

   localparam int unsigned CNT_W = $clog2(max_u(DIV_A, DIV_B));

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             wrap;

   assign last     = sel ? CNT_W'(DIV_B - 1) : CNT_W'(DIV_A - 1);
   assign wrap     = (cnt_q >= last);
   assign fb_pulse = tick & wrap;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/fmul_lockdet.sv
module fmul_lockdet
   import fmul_pkg::*;
#(
   parameter int unsigned LOCK_PERIODS = 16,
   parameter int unsigned GLITCH_MAX   = 2
) (
   input  logic   clk,
   input  logic   rst,
   input  steer_t steer,
   input  logic   ref_edge,
   output logic   locked
);

   localparam int unsigned RUN_W = $clog2(GLITCH_MAX + 2);
   localparam int unsigned CNT_W = $clog2(LOCK_PERIODS + 1);
   localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(GLITCH_MAX + 1);

   logic [RUN_W-1:0] run_q, run_n;
   logic [CNT_W-1:0] cnt_q;
   logic             bad_q, bad_now, lock_q;

   always_comb begin
      if (!(steer.adv || steer.ret)) run_n = '0;
      else if (run_q == RUN_TOP)     run_n = run_q;
      else                           run_n = run_q + 1'b1;
      bad_now = bad_q | (run_n > RUN_W'(GLITCH_MAX));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= '0;
         bad_q  <= 1'b0;
         cnt_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         run_q <= run_n;
         if (ref_edge) begin
            bad_q <= 1'b0;
            if (bad_now) begin
               cnt_q  <= '0;
               lock_q <= 1'b0;
            end else begin
               if (cnt_q < CNT_W'(LOCK_PERIODS)) cnt_q <= cnt_q + 1'b1;
               lock_q <= ({1'b0, cnt_q} + 1'b1) >= (CNT_W+1)'(LOCK_PERIODS);
            end
         end else begin
            bad_q <= bad_now;
         end
      end
   end

   assign locked = lock_q;

endmodule

// File: rtl/fmul_loop.sv
module fmul_loop
   import fmul_pkg::*;
#(
   parameter int unsigned ACC_W         = 16,
   parameter int unsigned TUNE_FRAC     = 4,
   parameter int unsigned TUNE_MIN_INT  = 64,
   parameter int unsigned TUNE_MAX_INT  = 8192,
   parameter int unsigned TUNE_INIT_INT = 1024,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned DIV_A         = 3,
   parameter int unsigned DIV_B         = 6,
   parameter int unsigned LOCK_PERIODS  = 16,
   parameter int unsigned GLITCH_MAX    = 2,
   localparam int unsigned TUNE_W       = ACC_W + TUNE_FRAC,
   localparam int unsigned IG_W         = $clog2(TUNE_W),
   localparam int unsigned PG_W         = $clog2(ACC_W)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ref_in,
   input  logic            div_sel,
   input  logic [IG_W-1:0] i_gain,
   input  logic [PG_W-1:0] p_gain,
   output logic            mult_en,
   output logic            sq_out,
   output logic            locked
);

   localparam int unsigned TUNE_MIN  = TUNE_MIN_INT  << TUNE_FRAC;
   localparam int unsigned TUNE_MAX  = TUNE_MAX_INT  << TUNE_FRAC;
   localparam int unsigned TUNE_INIT = TUNE_INIT_INT << TUNE_FRAC;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fmul_loop: SYNC_STAGES must be at least 2");
   end
   if (ACC_W < 4 || TUNE_W > 30) begin : g_bad_width
      $error("fmul_loop: ACC_W/TUNE_FRAC out of range");
   end
   if (!(TUNE_MIN_INT <= TUNE_INIT_INT && TUNE_INIT_INT <= TUNE_MAX_INT)) begin : g_bad_order
      $error("fmul_loop: tuning limits must bracket the start value");
   end
   if (TUNE_MAX_INT >= (1 << ACC_W)) begin : g_bad_max
      $error("fmul_loop: TUNE_MAX_INT exceeds accumulator range");
   end
   if (DIV_A < 2 || DIV_B < 2) begin : g_bad_div
      $error("fmul_loop: feedback ratios must be at least 2");
   end
   if (LOCK_PERIODS < 1) begin : g_bad_lock
      $error("fmul_loop: LOCK_PERIODS must be at least 1");
   end

   steer_t            steer;
   logic              ref_edge;
   logic              fb_pulse;
   logic [TUNE_W-1:0] tune;

   fmul_pfd #(.SYNC_STAGES(SYNC_STAGES)) u_pfd (
      .clk      (clk),
      .rst      (rst),
      .ref_in   (ref_in),
      .fb_pulse (fb_pulse),
      .ref_edge (ref_edge),
      .steer    (steer)
   );

   fmul_tune #(
      .TUNE_W    (TUNE_W),
      .IG_W      (IG_W),
      .TUNE_MIN  (TUNE_MIN),
      .TUNE_MAX  (TUNE_MAX),
      .TUNE_INIT (TUNE_INIT)
   ) u_tune (
      .clk    (clk),
      .rst    (rst),
      .steer  (steer),
      .i_gain (i_gain),
      .tune   (tune)
   );

   fmul_nco #(
      .ACC_W     (ACC_W),
      .TUNE_FRAC (TUNE_FRAC),
      .PG_W      (PG_W)
   ) u_nco (
      .clk     (clk),
      .rst     (rst),
      .tune    (tune),
      .steer   (steer),
      .p_gain  (p_gain),
      .mult_en (mult_en),
      .sq_out  (sq_out)
   );

   fmul_fbdiv #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_fbdiv (
      .clk      (clk),
      .rst      (rst),
      .tick     (mult_en),
      .sel      (div_sel),
      .fb_pulse (fb_pulse)
   );

   fmul_lockdet #(
      .LOCK_PERIODS (LOCK_PERIODS),
      .GLITCH_MAX   (GLITCH_MAX)
   ) u_lock (
      .clk      (clk),
      .rst      (rst),
      .steer    (steer),
      .ref_edge (ref_edge),
      .locked   (locked)
   );

endmodule

// File: rtl/fmul_loop_chk.sv
module fmul_loop_chk #(
   parameter int unsigned TUNE_W   = 20,
   parameter int unsigned TUNE_MIN = 0,
   parameter int unsigned TUNE_MAX = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              adv,
   input logic              ret,
   input logic [TUNE_W-1:0] tune,
   input logic              ref_edge,
   input logic              mult_en,
   input logic              sq_out,
   input logic              locked
);

   AST_TUNE_BOUNDS: assert property (@(posedge clk) disable iff (rst)
      (tune >= TUNE_W'(TUNE_MIN)) && (tune <= TUNE_W'(TUNE_MAX))); // R3

   AST_TUNE_RISES: assert property (@(posedge clk) disable iff (rst)
      (adv && !ret) |=> (tune >= $past(tune))); // R3

   AST_TUNE_FALLS: assert property (@(posedge clk) disable iff (rst)
      (ret && !adv) |=> (tune <= $past(tune))); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (adv == ret) |=> $stable(tune)); // R2

   AST_EN_SPACED: assert property (@(posedge clk) disable iff (rst)
      mult_en |=> !mult_en); // R4

   AST_SQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (sq_out != $past(sq_out)) == mult_en); // R5

   AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(ref_edge)); // R7

endmodule

bind fmul_loop fmul_loop_chk #(
   .TUNE_W   (TUNE_W),
   .TUNE_MIN (TUNE_MIN),
   .TUNE_MAX (TUNE_MAX)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .adv      (steer.adv),
   .ret      (steer.ret),
   .tune     (tune),
   .ref_edge (ref_edge),
   .mult_en  (mult_en),
   .sq_out   (sq_out),
   .locked   (locked)
);

// File: tb/fmul_loop_bench.sv
`timescale 1ns/1ps
module fmul_loop_bench;

   localparam int unsigned ACC_W = 12;
   localparam int unsigned FRAC  = 4;
   localparam int unsigned T_MIN = 40;
   localparam int unsigned T_MAX = 400;
   localparam int unsigned T_INI = 100;
   localparam int unsigned IG_W  = $clog2(ACC_W + FRAC);
   localparam int unsigned PG_W  = $clog2(ACC_W);
   localparam int          REF_P = 96;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            ref_in = 1'b0;
   logic            div_sel = 1'b0;
   logic [IG_W-1:0] i_gain = '0;
   logic [PG_W-1:0] p_gain = '0;
   logic            mult_en, sq_out, locked;

   int checks = 0;
   int fails  = 0;
   int ref_period = REF_P;
   int rcnt = 0;
   int cyc = 0;
   int spacing_err = 0;
   int toggle_err = 0;
   logic prev_en = 1'b0;
   logic prev_sq = 1'b0;

   always #2 clk = ~clk;

   fmul_loop #(
      .ACC_W         (ACC_W),
      .TUNE_FRAC     (FRAC),
      .TUNE_MIN_INT  (T_MIN),
      .TUNE_MAX_INT  (T_MAX),
      .TUNE_INIT_INT (T_INI)
   ) u_fmul_loop (
      .clk     (clk),
      .rst     (rst),
      .ref_in  (ref_in),
      .div_sel (div_sel),
      .i_gain  (i_gain),
      .p_gain  (p_gain),
      .mult_en (mult_en),
      .sq_out  (sq_out),
      .locked  (locked)
   );

   // reference generator: low half period, then high half period
   always @(negedge clk) begin
      if (rst || ref_period == 0) begin
         rcnt   <= 0;
         ref_in <= 1'b0;
      end else begin
         rcnt   <= (rcnt == ref_period - 1) ? 0 : rcnt + 1;
         ref_in <= (rcnt >= ref_period / 2);
      end
   end

   // continuous monitor of pulse spacing (R4) and square toggling (R5)
   always @(negedge clk) begin
      if (rst) begin
         prev_en = 1'b0;
         prev_sq = sq_out;
      end else begin
         if (prev_en && mult_en) spacing_err++;
         if ((sq_out != prev_sq) != mult_en) toggle_err++;
         prev_en = mult_en;
         prev_sq = sq_out;
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected < 190000", cyc);
         finish_run();
      end
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_rng(input string tag, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count_window(input int n, output int en_cnt, output int tg_cnt);
      logic last_sq;
      en_cnt = 0;
      tg_cnt = 0;
      last_sq = sq_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mult_en) en_cnt++;
         if (sq_out != last_sq) tg_cnt++;
         last_sq = sq_out;
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst = 1'b1;
      wait_cycles(4);
      rst = 1'b0;
   endtask

   initial begin
      int en_cnt, tg_cnt;

      // ---- reset state (R1) ----
      ref_period = REF_P;
      div_sel = 1'b0;
      i_gain  = IG_W'(0);
      p_gain  = PG_W'(6);
      rst = 1'b1;
      wait_cycles(4);
      check_eq("R1 mult_en in reset", int'(mult_en), 0);
      check_eq("R1 sq_out in reset",  int'(sq_out),  0);
      check_eq("R1 locked in reset",  int'(locked),  0);
      rst = 1'b0;

      // ---- R7: fewer than 16 reference edges so far, so no lock ----
      wait_cycles(15 * REF_P);
      check_eq("R7 no lock before 16 periods", int'(locked), 0);

      // ---- R6: ratio 3 lock and rate ----
      wait_cycles(40000);
      check_eq("R7 locked at ratio 3", int'(locked), 1);
      count_window(32 * REF_P, en_cnt, tg_cnt);
      check_rng("R6 pulses over 32 periods, ratio 3", en_cnt, 3 * 32 - 2, 3 * 32 + 2);
      check_eq("R5 square toggles match pulses", tg_cnt, en_cnt);

      // ---- R7: ratio change disturbs loop, lock drops ----
      div_sel = 1'b1;
      wait_cycles(4 * REF_P);
      check_eq("R7 lock lost after ratio change", int'(locked), 0);

      // ---- R6: ratio 6 relock and rate ----
      wait_cycles(60000);
      check_eq("R7 relocked at ratio 6", int'(locked), 1);
      count_window(32 * REF_P, en_cnt, tg_cnt);
      check_rng("R6 pulses over 32 periods, ratio 6", en_cnt, 6 * 32 - 2, 6 * 32 + 2);

      // ---- R8 / R3 / R4: reference stuck low, tuning at floor ----
      ref_period = 0;
      div_sel = 1'b0;
      i_gain  = IG_W'(4);  // 16 fraction units = 1 integer step per cycle
      p_gain  = PG_W'(2);  // kick 4
      apply_reset();
      wait_cycles(500);
      count_window(4096, en_cnt, tg_cnt);
      check_rng("R8 floor rate (min less kick) over 4096 cycles", en_cnt,
                int'(T_MIN) - 4 - 1, int'(T_MIN) - 4 + 1);
      check_eq("R8 no lock without reference", int'(locked), 0);

      // ---- R3 / R4: fast reference, tuning at ceiling ----
      ref_period = 8;
      p_gain  = PG_W'(0);  // kick 1
      apply_reset();
      wait_cycles(2000);
      count_window(4096, en_cnt, tg_cnt);
      check_rng("R3 ceiling rate over 4096 cycles", en_cnt,
                int'(T_MAX) - 1, int'(T_MAX) + 2);
      check_eq("R5 square toggles at ceiling", tg_cnt, en_cnt);

      // ---- aggregate monitors ----
      check_eq("R4 back-to-back enable pulses", spacing_err, 0);
      check_eq("R5 square toggles outside enable cycles", toggle_err, 0);

      finish_run();
   end

endmodule